// File: doc/BRIEF.md
# ARX Stream Cipher Block Core

This core produces one 64-byte keystream block for a stream cipher with a 256-bit key. It works on sixteen 32-bit words. The caller gives a key, a 64-bit nonce and a 64-bit block counter, then pulses `start` for one cycle. The core loads a 4x4 word state and runs add-rotate-xor rounds on it. It adds the starting words back into the result and presents the block with a one-cycle `done` pulse.

Each clock cycle performs one double-round, which is one column pass followed by one diagonal pass. The default of 20 rounds therefore takes ten cycles. XOR with the message, advancing the counter from block to block, and message authentication all belong to the surrounding logic.

Top module: `arx_block_core`

## Requirements
- R1: The starting state is built as follows. Words 0..3 are 0x61707865, 0x3320646E, 0x79622D32 and 0x6B206574. Words 4..11 are key words 0..7, where key word i is `key[32i+31:32i]`. Word 12 is `blk_ctr[31:0]` and word 13 is `blk_ctr[63:32]`. Words 14 and 15 are `nonce[31:0]` and `nonce[63:32]`.
- R2: A quarter-round on (a,b,c,d) runs these steps in order, all sums modulo 2^32: a+=b, d^=a, d rotl 16; c+=d, b^=c, b rotl 12; a+=b, d^=a, d rotl 8; c+=d, b^=c, b rotl 7.
- R3: One double-round first applies quarter-rounds to the columns (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15). It then applies them to the diagonals (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14).
- R4: After the last round, every working word is added modulo 2^32 to its starting word to form the output word.
- R5: `ROUNDS` may be 8, 12 or 20, and the default is 20. A start accepted at clock edge k raises `done` after edge k+ROUNDS/2.
- R6: `busy` is high from the edge that accepts a start until the edge that raises `done`. `done` lasts exactly one cycle and is never high together with `busy`.
- R7: A `start` pulse while `busy` is high is ignored. Key, nonce and counter changes during that time have no effect on the block being computed.
- R8: `blk_out` changes only at the edge that raises `done` and holds its value until the next completion.
- R9: Output word i is `blk_out[32i+31:32i]`, and each word is little-endian, so keystream byte n is `blk_out[8n+7:8n]`.
- R10: During and just after reset, `busy` and `done` are 0 and `blk_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block; taken only when idle |
| key | input | 256 | Key, word i at bits 32i+31:32i |
| nonce | input | 64 | Nonce, low word first |
| blk_ctr | input | 64 | Block counter, low word first |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse, block valid |
| blk_out | output | 512 | Keystream block, byte n at bits 8n+7:8n |

## Verification
The bench applies an all-zero key, nonce and counter and compares the result against the published first keystream bytes. A swapped rotate amount, a wrong diagonal group, or a missing final addition each corrupts every byte and fails this check. A counter with a non-zero high word catches a design that swaps the halves of the counter or of the nonce, because the block then differs from the model's block. Start pulses and input changes in the middle of a run catch a core that restarts or samples its inputs again while busy; such a core would produce the wrong block or a late `done`. A start issued in the cycle where `done` is visible, together with a second instance at 8 rounds, checks that completion timing and re-acceptance follow `ROUNDS`.

// File: rtl/arx_pkg.sv
package arx_pkg;
   localparam int WORD_W  = 32;
   localparam int N_WORDS = 16;
   localparam int BLK_W   = WORD_W * N_WORDS;

   typedef logic [WORD_W-1:0]  word_t;
   typedef word_t [N_WORDS-1:0] state_t;

   localparam word_t SIGMA0 = 32'h61707865;
   localparam word_t SIGMA1 = 32'h3320646E;
   localparam word_t SIGMA2 = 32'h79622D32;
   localparam word_t SIGMA3 = 32'h6B206574;

   function automatic word_t rotl(input word_t x, input int unsigned n);
      return (x << n) | (x >> (WORD_W - n));
   endfunction
endpackage

// File: rtl/arx_qround.sv
module arx_qround
   import arx_pkg::*;
(
   input  word_t a_i,
   input  word_t b_i,
   input  word_t c_i,
   input  word_t d_i,
   output word_t a_o,
   output word_t b_o,
   output word_t c_o,
   output word_t d_o
);
   word_t a1, b1, c1, d1;

   // first half: rotations 16 and 12
   assign a1 = a_i + b_i;
   assign d1 = rotl(d_i ^ a1, 16);
   assign c1 = c_i + d1;
   assign b1 = rotl(b_i ^ c1, 12);

   // second half: rotations 8 and 7
   assign a_o = a1 + b1;
   assign d_o = rotl(d1 ^ a_o, 8);
   assign c_o = c1 + d_o;
   assign b_o = rotl(b1 ^ c_o, 7);
endmodule

// File: rtl/arx_dround.sv
module arx_dround
   import arx_pkg::*;
(
   input  state_t st_i,
   output state_t st_o
);
   word_t col_w [N_WORDS];
   word_t dia_w [N_WORDS];

   for (genvar g = 0; g < 4; g++) begin : g_lane
      // column group g
      localparam int C0 = g;
      localparam int C1 = 4 + g;
      localparam int C2 = 8 + g;
      localparam int C3 = 12 + g;
      // diagonal group starting at word g
      localparam int D0 = g;
      localparam int D1 = 4 + ((g + 1) % 4);
      localparam int D2 = 8 + ((g + 2) % 4);
      localparam int D3 = 12 + ((g + 3) % 4);

      arx_qround u_col (
         .a_i(st_i[C0]), .b_i(st_i[C1]), .c_i(st_i[C2]), .d_i(st_i[C3]),
         .a_o(col_w[C0]), .b_o(col_w[C1]), .c_o(col_w[C2]), .d_o(col_w[C3])
      );

      arx_qround u_dia (
         .a_i(col_w[D0]), .b_i(col_w[D1]), .c_i(col_w[D2]), .d_i(col_w[D3]),
         .a_o(dia_w[D0]), .b_o(dia_w[D1]), .c_o(dia_w[D2]), .d_o(dia_w[D3])
      );
   end

   always_comb begin
      for (int i = 0; i < N_WORDS; i++) st_o[i] = dia_w[i];
   end
endmodule

// File: rtl/arx_block_core.sv
module arx_block_core
   import arx_pkg::*;
#(
   parameter int ROUNDS = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [255:0]       key,
   input  logic [63:0]        nonce,
   input  logic [63:0]        blk_ctr,
   output logic               busy,
   output logic               done,
   output logic [BLK_W-1:0]   blk_out
);
   localparam int DR    = ROUNDS / 2;
   localparam int CNT_W = (DR > 1) ? $clog2(DR) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DR - 1);

   if (ROUNDS != 8 && ROUNDS != 12 && ROUNDS != 20) begin : g_bad_rounds
      $error("arx_block_core: ROUNDS must be 8, 12 or 20");
   end

   state_t init_st, init_q, work_q, next_st, sum_st;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      init_st[0] = SIGMA0;
      init_st[1] = SIGMA1;
      init_st[2] = SIGMA2;
      init_st[3] = SIGMA3;
      for (int i = 0; i < 8; i++) init_st[4 + i] = key[32*i +: 32];
      init_st[12] = blk_ctr[31:0];
      init_st[13] = blk_ctr[63:32];
      init_st[14] = nonce[31:0];
      init_st[15] = nonce[63:32];
   end

   arx_dround u_dround (.st_i(work_q), .st_o(next_st));

   for (genvar w = 0; w < N_WORDS; w++) begin : g_feed
      assign sum_st[w] = next_st[w] + init_q[w];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         cnt_q   <= '0;
         init_q  <= '0;
         work_q  <= '0;
         blk_out <= '0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            work_q <= next_st;
            if (cnt_q == LAST) begin
               busy    <= 1'b0;
               done    <= 1'b1;
               cnt_q   <= '0;
               blk_out <= sum_st;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (start) begin
            init_q <= init_st;
            work_q <= init_st;
            busy   <= 1'b1;
            cnt_q  <= '0;
         end
      end
   end

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));
   assert_done_follows_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));
   assert_init_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(init_q));
   assert_out_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(blk_out));
endmodule

// File: tb/arx_block_core_tb.sv
module arx_block_core_tb;
   localparam int R_MAIN = 20;
   localparam int R_ALT  = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         start8 = 1'b0;
   logic [255:0] key = '0;
   logic [63:0]  nonce = '0;
   logic [63:0]  blk_ctr = '0;
   logic         busy, done, busy8, done8;
   logic [511:0] blk_out, blk_out8;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   arx_block_core #(.ROUNDS(R_MAIN)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .key(key), .nonce(nonce),
      .blk_ctr(blk_ctr), .busy(busy), .done(done), .blk_out(blk_out));

   arx_block_core #(.ROUNDS(R_ALT)) u_dut8 (
      .clk(clk), .rst_n(rst_n), .start(start8), .key(key), .nonce(nonce),
      .blk_ctr(blk_ctr), .busy(busy8), .done(done8), .blk_out(blk_out8));

   // ---------------- behavioural reference ----------------
   int unsigned rx [16];
   int unsigned ri [16];

   function automatic int unsigned rl(input int unsigned x, input int n);
      return (x << n) | (x >> (32 - n));
   endfunction

   function void qr(input int a, input int b, input int c, input int d);
      rx[a] = rx[a] + rx[b]; rx[d] = rl(rx[d] ^ rx[a], 16);
      rx[c] = rx[c] + rx[d]; rx[b] = rl(rx[b] ^ rx[c], 12);
      rx[a] = rx[a] + rx[b]; rx[d] = rl(rx[d] ^ rx[a], 8);
      rx[c] = rx[c] + rx[d]; rx[b] = rl(rx[b] ^ rx[c], 7);
   endfunction

   function logic [511:0] ref_block(input logic [255:0] k, input logic [63:0] n,
                                    input logic [63:0] c, input int rounds);
      logic [511:0] r;
      ri[0] = 32'h61707865; ri[1] = 32'h3320646E;
      ri[2] = 32'h79622D32; ri[3] = 32'h6B206574;
      for (int i = 0; i < 8; i++) ri[4+i] = k[32*i +: 32];
      ri[12] = c[31:0];  ri[13] = c[63:32];
      ri[14] = n[31:0];  ri[15] = n[63:32];
      for (int i = 0; i < 16; i++) rx[i] = ri[i];
      for (int r2 = 0; r2 < rounds; r2 += 2) begin
         qr(0, 4, 8, 12); qr(1, 5, 9, 13); qr(2, 6, 10, 14); qr(3, 7, 11, 15);
         qr(0, 5, 10, 15); qr(1, 6, 11, 12); qr(2, 7, 8, 13); qr(3, 4, 9, 14);
      end
      for (int i = 0; i < 16; i++) r[32*i +: 32] = rx[i] + ri[i];
      return r;
   endfunction

   // cycle model of the main instance
   logic         m_busy, m_done;
   logic [511:0] m_out;
   int           m_cnt;
   logic [255:0] m_key;
   logic [63:0]  m_nonce, m_ctr;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy <= 1'b0; m_done <= 1'b0; m_out <= '0; m_cnt <= 0;
      end else begin
         m_done <= 1'b0;
         if (m_busy) begin
            if (m_cnt == R_MAIN/2 - 1) begin
               m_busy <= 1'b0; m_done <= 1'b1;
               m_out  <= ref_block(m_key, m_nonce, m_ctr, R_MAIN);
            end
            m_cnt <= m_cnt + 1;
         end else if (start) begin
            m_busy <= 1'b1; m_cnt <= 0;
            m_key <= key; m_nonce <= nonce; m_ctr <= blk_ctr;
         end
      end
   end

   task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R6 busy vs model", 512'(busy), 512'(m_busy));
         chk("R5 done vs model", 512'(done), 512'(m_done));
         chk("R8 blk_out vs model", blk_out, m_out);
      end
   end

   // start a block, return negedge count until done
   task automatic run(output int lat, output int lat8, input bit use8,
                      input bit poke_busy);
      logic [255:0] k0;
      int n = 0;
      lat8 = 0;
      k0 = key;
      start = 1'b1;
      start8 = use8;
      do begin
         @(negedge clk);
         n++;
         if (n == 1) begin start = 1'b0; start8 = 1'b0; end
         if (poke_busy && n == 4) begin start = 1'b1; key = ~k0; blk_ctr = blk_ctr + 64'd7; end
         if (poke_busy && n == 5) begin start = 1'b0; end
         if (poke_busy && n == 6) begin key = k0; blk_ctr = blk_ctr - 64'd7; end
         if (done8 && lat8 == 0) lat8 = n;
      end while (!done && n < 100);
      lat = n;
   endtask

   initial begin
      int lat, lat8;
      logic [511:0] exp_blk;
      logic [511:0] out8_seen;
      // reset state, R10
      repeat (3) @(negedge clk);
      chk("R10 busy at reset", 512'(busy), 512'(0));
      chk("R10 done at reset", 512'(done), 512'(0));
      chk("R10 blk_out at reset", blk_out, 512'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 blk_out after reset", blk_out, 512'(0));

      // all-zero inputs: published keystream start (R1 R2 R3 R4 R9)
      run(lat, lat8, 1'b0, 1'b0);
      chk("R5 latency 20 rounds", 512'(lat), 512'(R_MAIN/2 + 1));
      chk("R2 word0 known answer", 512'(blk_out[31:0]), 512'(32'hade0b876));
      chk("R3 word1 known answer", 512'(blk_out[63:32]), 512'(32'h903df1a0));
      chk("R9 byte0 order", 512'(blk_out[7:0]), 512'(8'h76));
      chk("R9 byte5 order", 512'(blk_out[47:40]), 512'(8'hf1));
      chk("R4 full block zero inputs", blk_out, ref_block('0, '0, '0, R_MAIN));

      // structured key, counter with non-zero high word (R1), plus 8-round instance (R5)
      for (int j = 0; j < 32; j++) key[8*j +: 8] = 8'(j);
      nonce   = 64'h4a000000_09000000;
      blk_ctr = 64'h00000003_00000001;
      exp_blk = ref_block(key, nonce, blk_ctr, R_MAIN);
      run(lat, lat8, 1'b1, 1'b0);
      out8_seen = blk_out8;
      chk("R1 layout with counter halves", blk_out, exp_blk);
      chk("R5 latency 8 rounds", 512'(lat8), 512'(R_ALT/2 + 1));
      chk("R5 block for 8 rounds", out8_seen, ref_block(key, nonce, blk_ctr, R_ALT));

      // back-to-back start in the done cycle, with a start pulse mid-run (R7)
      nonce   = 64'hdeadbeef_01234567;
      blk_ctr = 64'hffffffff_fffffffe;
      exp_blk = ref_block(key, nonce, blk_ctr, R_MAIN);
      run(lat, lat8, 1'b0, 1'b1);
      chk("R7 mid-run start ignored", blk_out, exp_blk);
      chk("R7 latency unchanged", 512'(lat), 512'(R_MAIN/2 + 1));

      // hold: no done and stable output while idle (R8)
      repeat (5) @(negedge clk);
      chk("R8 output held while idle", blk_out, exp_blk);
      chk("R6 idle busy low", 512'(busy), 512'(0));

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog R5 actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule